// File: doc/BRIEF.md
# Self-Starting Power-On Reset Generator

This block makes its own reset after power is applied, in a device that has no reset pin and whose flip-flops come up holding arbitrary values. It uses a free-running counter that has no reset of its own. Every counter value except one terminal value is decoded as "reset active". The counter steps once per clock from whatever value it powered up with. When it reaches the terminal value it stops there, and the registered reset output drops and stays low.

The block also protects a group of actuator strobes, such as valve drives, from spurious activity during start-up. Each strobe passes through a gate that holds it at logic 0. The gate opens only after the rest of the system has issued its own reset, which is a short pulse that arrives long after power-up. The generated reset closes the gate. The first system pulse that arrives while the generated reset is low opens it, and it stays open from then on.

The method is probabilistic. If the counter happens to power up at the terminal value, no reset pulse is produced. That is 1 of the 2^8 start states.

Top module: `selfstart_por`

## Requirements
- R1: From any start value other than the terminal value 8'hFF, the counter advances by exactly one per clock (wrapping modulo 256).
- R2: The generated reset `por_rst_o` is a register. After each rising edge it is high if, before that edge, the counter held any value other than 8'hFF.
- R3: Once the counter holds 8'hFF it keeps that value on every later clock, and `por_rst_o` is low from the edge after it got there onward.
- R4: The length of the reset pulse depends only on the power-up counter value S. For S = 8'hFF there is no pulse at all. For any other S, `por_rst_o` is high for exactly 255 − S clocks after power-up.
- R5: When the gate is closed, every bit of `strobe_o` is 0 whatever `strobe_raw_i` holds. Any rising edge at which `por_rst_o` is high closes the gate.
- R6: The first rising edge at which `sys_rst_pulse_i` is high and `por_rst_o` is low opens the gate. From then on `strobe_o` equals `strobe_raw_i` bit for bit, including after the pulse has ended.
- R7: A system reset pulse that arrives while `por_rst_o` is high is ignored: the gate stays closed and the strobes stay 0.
- R8: `por_rst_o` changes only at a rising clock edge and holds its value for the rest of the cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running clock, present from power-up |
| sys_rst_pulse_i | input | 1 | Short late system reset pulse, active high |
| strobe_raw_i | input | N_STROBE | Actuator strobes before gating, active high |
| strobe_o | output | N_STROBE | Gated actuator strobes, 0 while the gate is closed |
| por_rst_o | output | 1 | Generated power-on reset, registered, active high |

## Verification
The hard part is the power-up state itself. The block has no reset input, so the ports cannot set the counter to a chosen start value, and they cannot load the terminal value or a gate that is already open. The bench imitates a power cycle: at a falling edge it briefly forces the state registers and the checker's start-up flag to chosen or random values, then releases them, and from then on it observes only the ports. The start values include 8'hFF with the gate open and with it closed, 8'hFE, 8'h00, and several random values. System pulses are placed inside the reset window, on its last cycle and just after it.

// File: rtl/por_pkg.sv
package por_pkg;

    // Default sizing of the power-on reset generator.
    localparam int DEF_CNT_W    = 8;
    localparam int DEF_N_STROBE = 4;

    // State of the actuator gate: open once the system reset has been seen.
    typedef struct packed {
        logic armed;
    } gate_state_t;

endpackage

// File: rtl/por_counter.sv
module por_counter #(
    parameter int              CNT_W    = por_pkg::DEF_CNT_W,
    parameter logic [CNT_W-1:0] TERM_VAL = '1
) (
    input  logic             clk_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             por_rst_o
);

    localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

    // No reset: both fields start from whatever the silicon powers up with.
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             rst;
    } cnt_state_t;

    cnt_state_t state_d, state_q;
    logic       at_term;

    always_comb begin
        state_d  = state_q;
        at_term  = (state_q.cnt == TERM_VAL);
        // Advance until the terminal value is reached, then freeze there.
        if (!at_term) begin
            state_d.cnt = state_q.cnt + STEP;
        end
        // Every value except the terminal one means "still in reset".
        state_d.rst = !at_term;
    end

    always_ff @(posedge clk_i) begin
        state_q <= state_d;
    end

    assign cnt_o     = state_q.cnt;
    assign por_rst_o = state_q.rst;

endmodule

// File: rtl/strobe_gate.sv
module strobe_gate #(
    parameter int N_STROBE = por_pkg::DEF_N_STROBE
) (
    input  logic                clk_i,
    input  logic                por_rst_i,
    input  logic                sys_rst_pulse_i,
    input  logic [N_STROBE-1:0] strobe_raw_i,
    output logic [N_STROBE-1:0] strobe_o
);

    por_pkg::gate_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (por_rst_i) begin
            // Generated reset closes the gate.
            state_d.armed = 1'b0;
        end else if (sys_rst_pulse_i) begin
            // Late system reset observed outside the generated reset: open.
            state_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        state_q <= state_d;
    end

    // One AND per strobe line, idle level 0.
    for (genvar g = 0; g < N_STROBE; g++) begin : g_line
        assign strobe_o[g] = strobe_raw_i[g] & state_q.armed;
    end

endmodule

// File: rtl/selfstart_por.sv
module selfstart_por #(
    parameter int               CNT_W    = por_pkg::DEF_CNT_W,
    parameter int               N_STROBE = por_pkg::DEF_N_STROBE,
    parameter logic [CNT_W-1:0] TERM_VAL = '1
) (
    input  logic                clk_i,
    input  logic                sys_rst_pulse_i,
    input  logic [N_STROBE-1:0] strobe_raw_i,
    output logic [N_STROBE-1:0] strobe_o,
    output logic                por_rst_o
);

    logic [CNT_W-1:0] por_cnt;
    logic             por_rst;

    por_counter #(
        .CNT_W    (CNT_W),
        .TERM_VAL (TERM_VAL)
    ) u_cnt (
        .clk_i     (clk_i),
        .cnt_o     (por_cnt),
        .por_rst_o (por_rst)
    );

    strobe_gate #(
        .N_STROBE (N_STROBE)
    ) u_gate (
        .clk_i           (clk_i),
        .por_rst_i       (por_rst),
        .sys_rst_pulse_i (sys_rst_pulse_i),
        .strobe_raw_i    (strobe_raw_i),
        .strobe_o        (strobe_o)
    );

    assign por_rst_o = por_rst;

endmodule

// File: rtl/selfstart_por_chk.sv
module selfstart_por_chk #(
    parameter int               CNT_W    = 8,
    parameter int               N_STROBE = 4,
    parameter logic [CNT_W-1:0] TERM_VAL = '1
) (
    input logic                clk_i,
    input logic [CNT_W-1:0]    cnt_i,
    input logic                por_rst_i,
    input logic                sys_rst_pulse_i,
    input logic [N_STROBE-1:0] strobe_raw_i,
    input logic [N_STROBE-1:0] strobe_o
);

    // Set after the first edge; the properties ignore the power-up cycle.
    logic alive_q = 1'b0;

    always_ff @(posedge clk_i) begin
        alive_q <= 1'b1;
    end

    p_count_step_r1: assert property (@(posedge clk_i) disable iff (!alive_q)
        (cnt_i != TERM_VAL) |=> (cnt_i == CNT_W'($past(cnt_i) + CNT_W'(1))));

    p_reset_decode_r2: assert property (@(posedge clk_i) disable iff (!alive_q)
        (cnt_i != TERM_VAL) |=> por_rst_i);

    p_frozen_r3: assert property (@(posedge clk_i) disable iff (!alive_q)
        (cnt_i == TERM_VAL) |=> ((cnt_i == TERM_VAL) && !por_rst_i));

    p_gate_closed_r5: assert property (@(posedge clk_i) disable iff (!alive_q)
        por_rst_i |=> (strobe_o == '0));

    p_gate_open_r6: assert property (@(posedge clk_i) disable iff (!alive_q)
        (sys_rst_pulse_i && !por_rst_i) |=> (strobe_o == strobe_raw_i));

    p_pulse_ignored_r7: assert property (@(posedge clk_i) disable iff (!alive_q)
        (por_rst_i && sys_rst_pulse_i) |=> (strobe_o == '0));

endmodule

bind selfstart_por selfstart_por_chk #(
    .CNT_W    (CNT_W),
    .N_STROBE (N_STROBE),
    .TERM_VAL (TERM_VAL)
) u_chk (
    .clk_i           (clk_i),
    .cnt_i           (por_cnt),
    .por_rst_i       (por_rst),
    .sys_rst_pulse_i (sys_rst_pulse_i),
    .strobe_raw_i    (strobe_raw_i),
    .strobe_o        (strobe_o)
);

// File: tb/test_selfstart_por.sv
`timescale 1ns/1ps
module test_selfstart_por;

    localparam int NS = 4;

    typedef struct {
        bit          first;
        bit          last;
        bit          por;
        logic [NS-1:0] strb;
        int          dur;
        string       tag_por;
        string       tag_strb;
        string       tag_dur;
    } exp_t;

    logic          clk = 1'b0;
    logic          sys_pulse = 1'b0;
    logic [NS-1:0] raw = '0;
    logic [NS-1:0] strobe;
    logic          por;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;
    exp_t sb_q[$];

    logic [7:0] frc_cnt;
    logic       frc_rst;
    logic       frc_arm;

    always #5 clk = ~clk;

    selfstart_por #(.CNT_W(8), .N_STROBE(NS), .TERM_VAL(8'hFF)) i_selfstart_por (
        .clk_i           (clk),
        .sys_rst_pulse_i (sys_pulse),
        .strobe_raw_i    (raw),
        .strobe_o        (strobe),
        .por_rst_o       (por)
    );

    // Driver: imitates a power cycle with arbitrary register contents,
    // then drives inputs and pushes the expected result of every edge.
    task automatic run_case(input logic [7:0] s, input bit arm0, input bit rst0,
                            input int pa, input int pb, input int ncyc);
        logic [7:0] m;
        bit         por_m, arm_m, por_n, arm_n;
        exp_t       e;
        @(negedge clk);
        frc_cnt = s; frc_rst = rst0; frc_arm = arm0;
        force i_selfstart_por.u_cnt.state_q   = {frc_cnt, frc_rst};
        force i_selfstart_por.u_gate.state_q  = frc_arm;
        force i_selfstart_por.u_chk.alive_q   = 1'b0;
        #1;
        release i_selfstart_por.u_cnt.state_q;
        release i_selfstart_por.u_gate.state_q;
        release i_selfstart_por.u_chk.alive_q;
        m = s; por_m = rst0; arm_m = arm0;
        for (int k = 0; k < ncyc; k++) begin
            sys_pulse = (k == pa) || (k == pb);
            raw       = NS'($urandom);
            // Expected behaviour at the coming rising edge.
            por_n = (m != 8'hFF);                       // R2 / R3
            arm_n = por_m ? 1'b0 : (arm_m | sys_pulse); // R5 / R6 / R7
            if (m != 8'hFF) m = m + 8'd1;               // R1
            e.first    = (k == 0);
            e.last     = (k == ncyc - 1);
            e.por      = por_n;
            e.strb     = arm_n ? raw : '0;
            e.dur      = (s == 8'hFF) ? 0 : 255 - int'(s); // R4
            e.tag_por  = por_n ? "R2" : "R3";
            e.tag_strb = (sys_pulse && por_m) ? "R7" : (arm_n ? "R6" : "R5");
            e.tag_dur  = (s == 8'hFF) ? "R4 (terminal start)" : "R4/R1 (pulse length)";
            sb_q.push_back(e);
            por_m = por_n; arm_m = arm_n;
            @(negedge clk);
        end
        sys_pulse = 1'b0;
    endtask

    // Monitor: pops one expectation per rising edge and compares.
    initial begin
        int hi;
        logic por_a;
        hi = 0;
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                if (e.first) hi = 0;
                por_a = por;
                checks++;
                if (por !== e.por) begin
                    errors++;
                    $display("FAIL %s: por_rst_o=%0b expected %0b", e.tag_por, por, e.por);
                end
                checks++;
                if (strobe !== e.strb) begin
                    errors++;
                    $display("FAIL %s: strobe_o=%b expected %b", e.tag_strb, strobe, e.strb);
                end
                if (por) hi++;
                #2;
                checks++;   // R8: no change within the cycle
                if (por !== por_a) begin
                    errors++;
                    $display("FAIL R8: por_rst_o moved mid-cycle to %0b expected %0b", por, por_a);
                end
                if (e.last) begin
                    checks++;
                    if (hi != e.dur) begin
                        errors++;
                        $display("FAIL %s: reset cycles=%0d expected %0d", e.tag_dur, hi, e.dur);
                    end
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(50000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // Start at zero: full-length pulse; one pulse inside the window (R7), one after (R6).
        run_case(8'h00, 1'b1, 1'b0, 100, 270, 300);
        // Terminal start, gate closed: no reset at all (R4), arming later (R6).
        run_case(8'hFF, 1'b0, 1'b0, 5, -1, 20);
        // Terminal start with reset register high: the first edge closes the gate (R5).
        run_case(8'hFF, 1'b1, 1'b1, 10, -1, 20);
        // One cycle of reset; pulses on the last reset cycle (R7) and just after (R6).
        run_case(8'hFE, 1'b1, 1'b1, 1, 2, 10);
        // Random start values and gate contents.
        for (int i = 0; i < 4; i++) begin
            run_case(8'($urandom_range(0, 255)), 1'($urandom), 1'($urandom), 256, -1, 270);
        end
        // Start near the end with no system pulse: the gate stays closed (R5).
        run_case(8'hF0, 1'b1, 1'b0, -1, -1, 30);
        // Terminal start with the gate open: strobes pass at once (the 1-in-256 case, R4).
        run_case(8'hFF, 1'b1, 1'b0, -1, -1, 8);
        wait (sb_q.size() == 0);
        #20;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule